// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative translation cache that sits in front of a page table walker. Each lookup request carries a virtual address. The upper bits form the page number, and that number is compared against every stored entry in the same cycle. When an entry matches, the block returns the stored frame number joined to the untouched offset bits. When no entry matches, the block raises a walk request with the page number and waits. The walker then supplies a translation on the refill port. That translation is installed, and the pending lookup is answered from it.

Each entry carries an occupied bit, a page tag, a frame number, a present flag and an age. The age orders the entries by recency: a hit or an install makes that entry the youngest, and an install without a free slot evicts the oldest. A present flag of zero marks a page that may not be touched, so a lookup that lands on it reports a fault instead of an address. A flush input empties the whole array in one cycle.

The controller has two states. In `ST_LOOKUP` it accepts requests. The transition `LOOKUP_MISS` moves it from `ST_LOOKUP` to `ST_WALK_WAIT` when an accepted request finds no match. The transition `WALK_DONE` moves it from `ST_WALK_WAIT` back to `ST_LOOKUP` when a refill arrives. Every other case keeps the current state.

Top module: `tlb_core`

## Requirements
- R1: After reset `resp_valid` and `miss_req` are 0, `req_ready` is 1, and no entry is occupied, so the first lookup misses.
- R2: A request accepted (`req_valid` and `req_ready` both high) whose page number matches an occupied entry yields `resp_valid`=1 in the next cycle, with `resp_fault`=0 when that entry's present flag is 1.
- R3: An accepted request that misses raises `miss_req` in the next cycle with `miss_vpn` equal to bits [31:12] of the request address. Both hold steady until a refill arrives. `req_ready` is 0 for that whole time, and any requests offered meanwhile produce no response.
- R4: A refill that arrives while the block waits produces `resp_valid`=1 one cycle later, with the refill frame joined to the waiting request's offset. The translation is installed, so the next lookup of that page hits.
- R5: When a lookup is answered from a translation whose present flag is 0, `resp_fault`=1 and `resp_paddr`=0. This applies both to the response after a refill and to a later hit.
- R6: An install with all 8 entries occupied replaces the least recently referenced one, where hits and installs both count as references. With a free entry present, nothing is evicted.
- R7: `flush` empties every entry in one cycle. A refill given in the same cycle is still installed after the clear.
- R8: A refill or flush in a cycle forces `req_ready` to 0. A request offered in that cycle is not accepted and produces neither a response nor a miss.
- R9: A refill whose page number is already stored overwrites that entry, so later lookups return the new frame.
- R10: A refill while no miss is pending installs the entry and produces no response.
- R11: `resp_paddr` is the 20-bit frame number in bits [31:12] above the request's bits [11:0], passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Response present this cycle |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Page is not present |
| miss_req | output | 1 | Walk request to the table walker |
| miss_vpn | output | 20 | Page number to walk |
| refill_valid | input | 1 | Translation supplied |
| refill_vpn | input | 20 | Page number of the translation |
| refill_pfn | input | 20 | Frame number of the translation |
| refill_present | input | 1 | Page may be accessed |
| flush | input | 1 | Empty all entries |

## Verification
The hardest state to reach from the ports is a full array whose recency order differs from its fill order. Only then does an eviction that picks the oldest-filled entry, rather than the least recently referenced one, become visible. The stimulus fills all eight entries through miss and refill pairs, then hits an early entry before forcing another install. Follow-up lookups then show which page survived. A long random phase follows. It draws from a pool of twelve pages, mixes in flushes and unsolicited refills, and lets a behavioural walker answer misses after random delays. This keeps the array at capacity with a constantly shifting recency order.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [0:0] {
        ST_LOOKUP    = 1'b0,
        ST_WALK_WAIT = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_entries.sv
module tlb_entries #(
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic               wr_present,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [VPN_W-1:0]   probe_vpn,
    output logic [ENTRIES-1:0] valid_vec,
    output logic               look_hit,
    output logic [IDX_W-1:0]   look_idx,
    output logic [PFN_W-1:0]   look_pfn,
    output logic               look_present,
    output logic               probe_hit,
    output logic [IDX_W-1:0]   probe_idx
);

    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [ENTRIES-1:0] pres_q;
    logic [ENTRIES-1:0] occ_q;
    logic [ENTRIES-1:0] look_vec;
    logic [ENTRIES-1:0] probe_vec;

    // parallel comparators, one pair per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign look_vec[g]  = occ_q[g] && (tag_q[g] == look_vpn);
        assign probe_vec[g] = occ_q[g] && (tag_q[g] == probe_vpn);
    end

    // lowest index wins if more than one line matched
    always_comb begin
        look_idx  = '0;
        probe_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (look_vec[i])  look_idx  = IDX_W'(i);
            if (probe_vec[i]) probe_idx = IDX_W'(i);
        end
    end

    assign look_hit     = |look_vec;
    assign probe_hit    = |probe_vec;
    assign look_pfn     = pfn_q[look_idx];
    assign look_present = pres_q[look_idx];
    assign valid_vec    = occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) occ_q[i] <= 1'b1;
                else if (flush)                     occ_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tag_q[i]  <= wr_vpn;
                pfn_q[i]  <= wr_pfn;
                pres_q[i] <= wr_present;
            end
        end
    end

    // R9
    unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec) && $onehot0(probe_vec));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush && !wr_en) |-> (occ_q == '0));

    // R7
    flush_keep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush && wr_en) |-> ($countones(occ_q) == 1));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] oldest_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == OLDEST);
    end

    // the oldest line unless a free one exists; lowest free index first
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oldest_vec[i]) victim_idx = IDX_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    // ages form a permutation; touching makes an entry youngest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (touch_idx == IDX_W'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // R6
    single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec));

    // R6
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&valid_vec)) |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFF_W-1:0] req_off,
    input  logic             refill_valid,
    input  logic [PFN_W-1:0] refill_pfn,
    input  logic             refill_present,
    input  logic             flush,
    input  logic             look_hit,
    input  logic [PFN_W-1:0] look_pfn,
    input  logic             look_present,
    output logic             req_ready,
    output logic             accept,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             miss_req,
    output logic [VPN_W-1:0] miss_vpn
);

    tlb_state_e       state_q, state_d;
    logic [OFF_W-1:0] pend_off_q;

    assign req_ready = (state_q == ST_LOOKUP) && !refill_valid && !flush;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:    if (accept && !look_hit) state_d = ST_WALK_WAIT;
            ST_WALK_WAIT: if (refill_valid)        state_d = ST_LOOKUP;
            default:      state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= 1'b0;
            miss_req   <= 1'b0;
            miss_vpn   <= '0;
            pend_off_q <= '0;
        end else begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= 1'b0;
            if ((state_q == ST_WALK_WAIT) && refill_valid) begin
                resp_valid <= 1'b1;
                resp_fault <= !refill_present;
                if (refill_present) resp_paddr <= {refill_pfn, pend_off_q};
            end else if (accept && look_hit) begin
                resp_valid <= 1'b1;
                resp_fault <= !look_present;
                if (look_present) resp_paddr <= {look_pfn, req_off};
            end
            if (accept && !look_hit) begin
                miss_vpn   <= req_vpn;
                pend_off_q <= req_off;
            end
            miss_req <= (state_d == ST_WALK_WAIT);
        end
    end

    // R3
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && !refill_valid) |=> (miss_req && $stable(miss_vpn)));

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && (resp_paddr == '0)));

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req || refill_valid || flush) |-> !req_ready);

    // R2
    resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past((req_valid && req_ready) || (miss_req && refill_valid)));

endmodule

// File: rtl/tlb_core.sv
module tlb_core #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  resp_valid,
    output logic [PA_W-1:0]       resp_paddr,
    output logic                  resp_fault,
    output logic                  miss_req,
    output logic [VA_W-OFF_W-1:0] miss_vpn,
    input  logic                  refill_valid,
    input  logic [VA_W-OFF_W-1:0] refill_vpn,
    input  logic [PA_W-OFF_W-1:0] refill_pfn,
    input  logic                  refill_present,
    input  logic                  flush
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic [ENTRIES-1:0] valid_vec;
    logic               look_hit, look_present, probe_hit, accept;
    logic [IDX_W-1:0]   look_idx, probe_idx, victim_idx, wr_idx, touch_idx;
    logic [PFN_W-1:0]   look_pfn;
    logic               touch_en;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    // an existing line for the same page is rewritten in place
    assign wr_idx    = probe_hit ? probe_idx : victim_idx;
    assign touch_en  = refill_valid || (accept && look_hit);
    assign touch_idx = refill_valid ? wr_idx : look_idx;

    tlb_entries #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_entries (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(refill_valid), .wr_idx(wr_idx), .wr_vpn(refill_vpn),
        .wr_pfn(refill_pfn), .wr_present(refill_present),
        .look_vpn(req_vpn), .probe_vpn(refill_vpn),
        .valid_vec(valid_vec), .look_hit(look_hit), .look_idx(look_idx),
        .look_pfn(look_pfn), .look_present(look_present),
        .probe_hit(probe_hit), .probe_idx(probe_idx)
    );

    tlb_lru #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_vec(valid_vec), .victim_idx(victim_idx)
    );

    tlb_ctrl #(
        .OFF_W(OFF_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .PA_W(PA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_off(req_off), .refill_valid(refill_valid), .refill_pfn(refill_pfn),
        .refill_present(refill_present), .flush(flush), .look_hit(look_hit),
        .look_pfn(look_pfn), .look_present(look_present), .req_ready(req_ready),
        .accept(accept), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .miss_req(miss_req), .miss_vpn(miss_vpn)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!resp_valid && !miss_req));

endmodule

// File: tb/sim_tlb_core.sv
module sim_tlb_core;
    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 8;

    logic        clk = 1'b0;
    logic        rst_n, req_valid, refill_valid, refill_present, flush;
    logic [31:0] req_vaddr;
    logic [19:0] refill_vpn, refill_pfn;
    logic        req_ready, resp_valid, resp_fault, miss_req;
    logic [31:0] resp_paddr;
    logic [19:0] miss_vpn;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur = "R1";

    // behavioural model: translations ordered most recent first
    logic [19:0] q_vpn[$];
    logic [19:0] q_pfn[$];
    bit          q_pres[$];
    bit          m_wait = 0;
    logic [19:0] m_pvpn = '0;
    logic [11:0] m_poff = '0;
    bit          e_rv = 0, e_f = 0, e_mr = 0;
    logic [31:0] e_pa = '0;

    tlb_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .miss_req(miss_req), .miss_vpn(miss_vpn),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_pfn(refill_pfn),
        .refill_present(refill_present), .flush(flush)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    function automatic int mfind(input logic [19:0] v);
        for (int i = 0; i < q_vpn.size(); i++) if (q_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic m_insert(input logic [19:0] v, input logic [19:0] p, input bit pr);
        int k;
        k = mfind(v);
        if (k >= 0) begin q_vpn.delete(k); q_pfn.delete(k); q_pres.delete(k); end
        q_vpn.push_front(v); q_pfn.push_front(p); q_pres.push_front(pr);
        if (q_vpn.size() > CAP) begin
            void'(q_vpn.pop_back()); void'(q_pfn.pop_back()); void'(q_pres.pop_back());
        end
    endtask

    task automatic m_step();
        bit acc;
        int k;
        logic [19:0] v, p;
        bit pr;
        acc  = !m_wait && !refill_valid && !flush && req_valid;
        e_rv = 0; e_f = 0; e_pa = '0;
        if (m_wait && refill_valid) begin
            e_rv = 1; e_f = !refill_present;
            e_pa = refill_present ? {refill_pfn, m_poff} : 32'h0;
            m_wait = 0;
        end else if (acc) begin
            k = mfind(req_vaddr[31:12]);
            if (k >= 0) begin
                v = q_vpn[k]; p = q_pfn[k]; pr = q_pres[k];
                q_vpn.delete(k); q_pfn.delete(k); q_pres.delete(k);
                q_vpn.push_front(v); q_pfn.push_front(p); q_pres.push_front(pr);
                e_rv = 1; e_f = !pr;
                e_pa = pr ? {p, req_vaddr[11:0]} : 32'h0;
            end else begin
                m_wait = 1; m_pvpn = req_vaddr[31:12]; m_poff = req_vaddr[11:0];
            end
        end
        if (flush) begin q_vpn.delete(); q_pfn.delete(); q_pres.delete(); end
        if (refill_valid) m_insert(refill_vpn, refill_pfn, refill_present);
        e_mr = m_wait;
    endtask

    // one clock: check ready, let the edge pass, update model, compare outputs
    task automatic cyc();
        bit rdy;
        #1;
        rdy = !m_wait && !refill_valid && !flush;
        chk(req_ready === rdy, "R8", "req_ready", 32'(req_ready), 32'(rdy));
        @(posedge clk);
        m_step();
        @(negedge clk);
        chk(resp_valid === e_rv, cur, "resp_valid", 32'(resp_valid), 32'(e_rv));
        if (e_rv) begin
            chk(resp_paddr === e_pa, cur, "resp_paddr", resp_paddr, e_pa);
            chk(resp_fault === e_f, cur, "resp_fault", 32'(resp_fault), 32'(e_f));
        end
        chk(miss_req === e_mr, cur, "miss_req", 32'(miss_req), 32'(e_mr));
        if (e_mr) chk(miss_vpn === m_pvpn, cur, "miss_vpn", 32'(miss_vpn), 32'(m_pvpn));
    endtask

    task automatic lookup(input logic [31:0] a);
        req_valid = 1; req_vaddr = a;
        cyc();
        req_valid = 0;
    endtask

    task automatic refill(input logic [19:0] v, input logic [19:0] p, input bit pr);
        refill_valid = 1; refill_vpn = v; refill_pfn = p; refill_present = pr;
        cyc();
        refill_valid = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        cyc();
        flush = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=0", 1);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_vaddr = '0; refill_valid = 0;
        refill_vpn = '0; refill_pfn = '0; refill_present = 0; flush = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: quiet outputs after reset
        chk(!resp_valid && !miss_req && req_ready, "R1", "reset outputs",
            {29'b0, resp_valid, miss_req, req_ready}, 32'h1);

        // R1 and R3: first lookup misses, walk request held
        cur = "R3";
        lookup(32'h12345ABC);
        chk(miss_req === 1'b1, "R1", "empty lookup miss", 32'(miss_req), 32'h1);
        chk(miss_vpn === 20'h12345, "R3", "miss_vpn", 32'(miss_vpn), 32'h12345);
        for (int i = 0; i < 3; i++) begin
            lookup(32'h00099000);
            chk(!resp_valid && miss_req, "R3", "ignored while waiting",
                {30'b0, resp_valid, miss_req}, 32'h1);
        end

        // R4: refill answers the pending lookup
        cur = "R4";
        refill(20'h12345, 20'h00ABC, 1);
        chk(resp_valid && resp_paddr == 32'h00ABCABC, "R4", "refill response",
            resp_paddr, 32'h00ABCABC);

        // R2 and R11: hit one cycle later with offset passed through
        cur = "R2";
        lookup(32'h12345010);
        chk(resp_valid === 1'b1, "R2", "hit response", 32'(resp_valid), 32'h1);
        chk(resp_paddr === 32'h00ABC010, "R11", "hit address", resp_paddr, 32'h00ABC010);

        // R5: page not present faults on walk and on later hit
        cur = "R5";
        lookup(32'h00777123);
        refill(20'h00777, 20'h00321, 0);
        chk(resp_fault && resp_paddr == 0, "R5", "walk fault", resp_paddr, 32'h0);
        lookup(32'h00777456);
        chk(resp_valid && resp_fault, "R5", "hit fault",
            {30'b0, resp_valid, resp_fault}, 32'h3);

        // R6: fill all entries, refresh page 1, then force an eviction
        cur = "R6";
        do_flush();
        for (int v = 1; v <= 8; v++) begin
            lookup({20'(v), 12'h004});
            refill(20'(v), 20'(v + 256), 1);
        end
        lookup({20'd1, 12'h008});
        lookup({20'd9, 12'h00C});
        refill(20'd9, 20'd265, 1);
        lookup({20'd1, 12'h010});
        chk(resp_valid === 1'b1, "R6", "refreshed page kept", 32'(resp_valid), 32'h1);
        lookup({20'd2, 12'h010});
        chk(miss_req === 1'b1, "R6", "oldest page evicted", 32'(miss_req), 32'h1);
        refill(20'd2, 20'd258, 1);
        lookup({20'd4, 12'h000});
        chk(resp_valid === 1'b1, "R6", "younger page kept", 32'(resp_valid), 32'h1);

        // R7: flush empties; refill in same cycle survives
        cur = "R7";
        do_flush();
        lookup({20'd4, 12'h000});
        chk(miss_req === 1'b1, "R7", "miss after flush", 32'(miss_req), 32'h1);
        refill(20'd4, 20'd260, 1);
        flush = 1;
        refill(20'h00055, 20'h0AAAA, 1);
        flush = 0;
        lookup(32'h00055020);
        chk(resp_valid && resp_paddr == 32'h0AAAA020, "R7", "refill kept over flush",
            resp_paddr, 32'h0AAAA020);

        // R8: refill and request in the same cycle
        cur = "R8";
        req_valid = 1; req_vaddr = 32'h00888000;
        refill_valid = 1; refill_vpn = 20'h00077; refill_pfn = 20'h00177; refill_present = 1;
        #1;
        chk(req_ready === 1'b0, "R8", "ready low on refill", 32'(req_ready), 32'h0);
        cyc();
        req_valid = 0; refill_valid = 0;
        chk(!resp_valid && !miss_req, "R8", "request dropped",
            {30'b0, resp_valid, miss_req}, 32'h0);

        // R10 and R9: unsolicited refill, then overwrite same page
        cur = "R10";
        refill(20'h00066, 20'h0000A, 1);
        chk(resp_valid === 1'b0, "R10", "no response", 32'(resp_valid), 32'h0);
        cur = "R9";
        refill(20'h00066, 20'h0000B, 1);
        lookup(32'h00066001);
        chk(resp_paddr === 32'h0000B001, "R9", "overwritten frame", resp_paddr, 32'h0000B001);

        // mixed traffic with a behavioural walker
        cur = "R2";
        for (int n = 0; n < 3000; n++) begin
            req_valid = ($urandom_range(0, 1) == 1);
            req_vaddr = {20'($urandom_range(0, 11) * 4369), 12'($urandom_range(0, 4095))};
            flush = ($urandom_range(0, 99) == 0);
            if (miss_req && $urandom_range(0, 2) == 0) begin
                refill_valid = 1; refill_vpn = miss_vpn;
            end else if ($urandom_range(0, 39) == 0) begin
                refill_valid = 1; refill_vpn = 20'($urandom_range(0, 11) * 4369);
            end else begin
                refill_valid = 0;
            end
            refill_pfn = refill_vpn ^ 20'h5A5A5;
            refill_present = (refill_vpn % 7) != 0;
            cyc();
        end
        req_valid = 0; refill_valid = 0; flush = 0;

        done = 1;
        summary();
        $finish;
    end
endmodule